// File: doc/BRIEF.md
# Periodic Driver Impedance Step Controller

This block holds the digital setting for an output driver whose strength comes from legs of binary-weighted impedance. A higher code turns on more leg weight, which gives a lower output impedance. A free-running cycle counter decides when the setting is re-evaluated. When the counter reaches a programmable period, it raises an evaluation strobe, clears itself and starts counting again. Because of this, the setting keeps tracking supply and temperature drift for as long as the clock runs.

The block reads an analog comparator through two inputs. One input says the present impedance is too high and the other says it is too low. Both inputs pass through a two-flop synchronizer before they are used. On each evaluation the code moves by exactly one step in the indicated direction, or it stays where it is. The code saturates at both ends. Every change lands in a single register cycle and is marked by a one-cycle update strobe, so the driver never sees a code that has only partly changed.

Top module: `imp_step_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, code_o equals mid-scale (32 for a 6-bit code), and upd_o and eval_o are low.
- R2: The counter starts at zero after reset. eval_o first goes high after period_i+1 rising edges following reset release, and after that every period_i+1 cycles.
- R3: For period_i of at least 1, eval_o is high for exactly one cycle per evaluation.
- R4: When an evaluation sees too_high_i=1 and too_low_i=0, code_o rises by one in the cycle after eval_o, and upd_o is high in that same cycle.
- R5: When an evaluation sees too_low_i=1 and too_high_i=0, code_o falls by one in the cycle after eval_o, and upd_o is high in that same cycle.
- R6: When an evaluation sees both comparator inputs low (matched) or both high (invalid), code_o stays unchanged and upd_o stays low.
- R7: code_o saturates without wrapping. A step up at all-ones and a step down at all-zeros leave the code unchanged and upd_o low.
- R8: code_o changes only in a cycle where upd_o is high, and then by exactly one step.
- R9: An evaluation uses the comparator value from two edges before it. A comparator change applied in the cycle where eval_o is high has no effect on that evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| period_i | input | 16 | Evaluation period; an evaluation fires every period_i+1 cycles |
| too_high_i | input | 1 | Comparator: present impedance is above the target |
| too_low_i | input | 1 | Comparator: present impedance is below the target |
| code_o | output | 6 | Binary-weighted driver leg code |
| upd_o | output | 1 | One-cycle strobe marking a new code value |
| eval_o | output | 1 | One-cycle evaluation strobe |

## Verification
The assertions assume that period_i is held steady across an evaluation. When it is not, the isolated-strobe property is waived for that cycle. They also assume the comparator inputs are quasi-static with respect to the evaluation rate. The bench programs the period only while reset is asserted. It changes the comparator inputs only just after an update, which leaves several cycles for the synchronizer to settle before the next evaluation edge. The one deliberate exception is the R9 case, where an input is changed in the cycle where eval_o is high.

// File: rtl/imp_pkg.sv
package imp_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } step_dir_e;
endpackage

// File: rtl/imp_cmp_sync.sv
module imp_cmp_sync
  import imp_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      too_high_i,
  input  logic      too_low_i,
  output step_dir_e dir_o
);
  localparam int unsigned NBITS = 2;

  logic [NBITS-1:0] raw;
  logic [NBITS-1:0] synced;

  assign raw = {too_low_i, too_high_i};

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], raw[b]};
    end
    assign synced[b] = chain_q[STAGES-1];
  end

  // both or neither asserted -> hold
  always_comb begin
    unique case (synced)
      2'b01:   dir_o = DIR_UP;
      2'b10:   dir_o = DIR_DOWN;
      default: dir_o = DIR_HOLD;
    endcase
  end
endmodule

// File: rtl/imp_eval_timer.sv
module imp_eval_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             hit;
  logic             tick_q;

  // >= so that a shortened period cannot strand the counter
  assign hit = (cnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= hit ? '0 : cnt_q + 1'b1;
      tick_q <= hit;
    end
  end

  assign tick_o = tick_q;

  assert_tick_isolated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_q && period_i != '0 && $stable(period_i)) |=> !tick_q);
endmodule

// File: rtl/imp_code_stepper.sv
module imp_code_stepper
  import imp_pkg::*;
#(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  step_dir_e         dir_i,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] MAX_CODE = '1;
  localparam logic [CODE_W-1:0] MIN_CODE = '0;

  logic [CODE_W-1:0] code_q, code_d;
  logic              upd_q, upd_d;

  always_comb begin
    code_d = code_q;
    upd_d  = 1'b0;
    if (tick_i) begin
      unique case (dir_i)
        DIR_UP: if (code_q != MAX_CODE) begin
          code_d = code_q + 1'b1;
          upd_d  = 1'b1;
        end
        DIR_DOWN: if (code_q != MIN_CODE) begin
          code_d = code_q - 1'b1;
          upd_d  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= MID_CODE;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      upd_q  <= upd_d;
    end
  end

  assign code_o = code_q;
  assign upd_o  = upd_q;

  assert_single_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> (code_q == CODE_W'($past(code_q) + 1'b1)) ||
              (CODE_W'(code_q + 1'b1) == $past(code_q)));

  assert_idle_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(code_q) && !upd_q));

  assert_hold_on_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && dir_i == DIR_HOLD) |=> ($stable(code_q) && !upd_q));

  assert_sat_top_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && dir_i == DIR_UP && code_q == MAX_CODE) |=> (code_q == MAX_CODE && !upd_q));

  assert_sat_bottom_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && dir_i == DIR_DOWN && code_q == MIN_CODE) |=> (code_q == MIN_CODE && !upd_q));

  assert_upd_follows_eval_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> $past(tick_i));
endmodule

// File: rtl/imp_step_ctrl.sv
module imp_step_ctrl
  import imp_pkg::*;
#(
  parameter int unsigned CODE_W      = 6,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  period_i,
  input  logic              too_high_i,
  input  logic              too_low_i,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o,
  output logic              eval_o
);
  step_dir_e dir;
  logic      tick;

  imp_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .too_high_i (too_high_i),
    .too_low_i  (too_low_i),
    .dir_o      (dir)
  );

  imp_eval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (period_i),
    .tick_o   (tick)
  );

  imp_code_stepper #(.CODE_W(CODE_W)) u_stepper (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .dir_i  (dir),
    .code_o (code_o),
    .upd_o  (upd_o)
  );

  assign eval_o = tick;
endmodule

// File: tb/imp_step_ctrl_tb.sv
module imp_step_ctrl_tb;
  localparam int unsigned CODE_W = 6;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned PERIOD = 7;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [CNT_W-1:0]  period_i = CNT_W'(PERIOD);
  logic              too_high_i = 1'b0;
  logic              too_low_i = 1'b0;
  logic [CODE_W-1:0] code_o;
  logic              upd_o;
  logic              eval_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_code;

  imp_step_ctrl u_dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // waits at negedges until eval_o is seen; returns cycles waited
  task automatic wait_eval(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!eval_o && n < 1000);
  endtask

  task automatic test_reset();
    @(negedge clk_i);
    check("R1 code", code_o, 32);
    check("R1 upd", upd_o, 0);
    check("R1 eval", eval_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic test_period();
    int n;
    wait_eval(n);
    check("R2 first eval", n, PERIOD + 1);
    @(negedge clk_i);
    check("R3 eval width", eval_o, 0);
    wait_eval(n);
    check("R2 interval", n + 1, PERIOD + 1);
  endtask

  // at negedge where eval_o is high: a change now must be ignored
  task automatic test_sync_delay();
    too_high_i = 1'b1;
    @(negedge clk_i);
    check("R9 code", code_o, 32);
    check("R9 upd", upd_o, 0);
  endtask

  task automatic step(string req, bit hi, bit lo);
    int n;
    int prev;
    too_high_i = hi;
    too_low_i  = lo;
    prev = exp_code;
    if (hi && !lo && exp_code < 63) exp_code++;
    else if (lo && !hi && exp_code > 0) exp_code--;
    wait_eval(n);
    check({req, " pre"}, code_o, prev);
    @(negedge clk_i);
    check({req, " code"}, code_o, exp_code);
    check({req, " upd"}, upd_o, (exp_code != prev) ? 1 : 0);
  endtask

  initial begin
    exp_code = 32;
    test_reset();
    test_period();
    test_sync_delay();
    step("R4", 1, 0);
    step("R4", 1, 0);
    step("R5", 0, 1);
    step("R6 matched", 0, 0);
    step("R6 both", 1, 1);
    for (int i = 0; i < 33; i++) step("R7 top", 1, 0);
    check("R7 top code", code_o, 63);
    for (int i = 0; i < 65; i++) step("R7 bottom", 0, 1);
    check("R7 bottom code", code_o, 0);
    step("R8 recover", 1, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule